// File: doc/BRIEF.md
# Branch and Call Sequencer

This block owns the program counter of a small command-processor core. Each cycle it takes one decoded control-flow operation, together with a register operand, an immediate, a bit selector, a signed relative offset and an absolute target, and produces the address of the next instruction to fetch. Relative branches can test a whole register against an immediate or test a single bit. Jumps can use an absolute target or a register-indexed target.

Two call styles are supported side by side. The first is a call that pushes its return address onto an internal hardware return stack, paired with a return that pops it. The second is a branch-and-link that stores its return address in a link register, paired with a return that reads that register. A wait operation holds the sequencer in place until the host's input write pointer moves. A preemption request diverts execution to a programmable handler entry, and a dedicated return brings execution back to the interrupted point.

The ALU and the instruction memory sit outside this block. The core presents the instruction found at `fetchPc` together with its decoded fields.

Top module: `flow_sequencer`

## Requirements
- R1: After reset, `fetchPc`, `linkReg`, `stackErr` and `inHandler` are all zero and the return stack is empty.
- R2: The opcode field is 4 bits wide. A valid NOP (code 0), or a valid unused code (13 to 15), advances `fetchPc` by one. While `opValid` is low, `fetchPc` holds its value.
- R3: Equality branches use codes 1 (taken when `regVal == immVal`) and 2 (taken when they differ). A taken branch sets `fetchPc` to the branch's own address plus the sign-extended `relOff`. An untaken branch advances `fetchPc` by one.
- R4: Bit branches use codes 3 (taken when `regVal[bitSel]` is 1) and 4 (taken when it is 0). They use the same relative target rule as R3.
- R5: CALL (code 5) pushes `fetchPc + 1` and jumps to `absAddr`. RET (code 6) pops the most recent entry and jumps to it, so returns come back in last-in, first-out order.
- R6: The return stack holds 8 entries. A CALL on a full stack still jumps but leaves the stack unchanged. A RET on an empty stack advances `fetchPc` by one. Either case sets `stackErr`, which stays set until reset.
- R7: BL (code 7) writes `fetchPc + 1` into `linkReg`, jumps to `absAddr` and leaves the stack untouched. SRET (code 8) jumps to `linkReg`.
- R8: JUMPR (code 9) jumps to `absAddr + regVal` modulo 2^ADDR_W. JUMPA (code 10) jumps to `absAddr`.
- R9: WAITIN (code 12) advances by one when `wptrMoved` is high in the same cycle. Otherwise `fetchPc` holds and `stalled` is high combinationally.
- R10: When `preemptReq` is high and `inHandler` is low, the current instruction completes. Its next address is saved, `fetchPc` loads `preemptEntry`, and `inHandler` rises. Requests are ignored while `inHandler` is high.
- R11: IRET (code 11) loads `fetchPc` with the saved address and clears `inHandler`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An instruction is presented this cycle |
| opCode | input | 4 | Control-flow operation code |
| regVal | input | DATA_W | Register operand |
| immVal | input | DATA_W | Immediate compare value |
| bitSel | input | $clog2(DATA_W) | Bit index for bit branches |
| relOff | input | OFF_W | Signed relative offset |
| absAddr | input | ADDR_W | Absolute target or jump base |
| wptrMoved | input | 1 | Input write pointer advanced |
| preemptReq | input | 1 | Preemption request |
| preemptEntry | input | ADDR_W | Handler entry address |
| fetchPc | output | ADDR_W | Current fetch address |
| linkReg | output | ADDR_W | Link register |
| stalled | output | 1 | Waiting for input |
| inHandler | output | 1 | Preemption handler active |
| stackErr | output | 1 | Sticky stack overflow or underflow |

## Verification
The bench exercises negative relative offsets, bit tests at bit 0 and bit 31, register-indexed jumps that wrap past the top of the address space, and both edges of the stack. That means a ninth nested call, then a return on an empty stack after eight returns. An off-by-one depth counter would corrupt return order or flag an error one call too early. It also raises preemption during a stalled wait and during an active handler. A design that saved the wrong address would resume one instruction off after IRET. A design that did not mask nested requests would lose the first saved address.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_BREQI  = 4'd1,
    OP_BRNEI  = 4'd2,
    OP_BREQB  = 4'd3,
    OP_BRNEB  = 4'd4,
    OP_CALL   = 4'd5,
    OP_RET    = 4'd6,
    OP_BL     = 4'd7,
    OP_SRET   = 4'd8,
    OP_JUMPR  = 4'd9,
    OP_JUMPA  = 4'd10,
    OP_IRET   = 4'd11,
    OP_WAITIN = 4'd12
  } flowOp_e;

  typedef enum logic [2:0] {
    NX_SEQ, NX_HOLD, NX_REL, NX_ABS, NX_REGOFF, NX_STACK, NX_LINK, NX_SAVED
  } nextSel_e;

  typedef struct packed {
    nextSel_e nextSel;
    logic     push;
    logic     pop;
    logic     linkWr;
    logic     takePreempt;
    logic     leaveHandler;
  } flowCtl_t;

endpackage

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import flow_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] immVal,
  input  logic [BIT_W-1:0]  bitSel,
  input  logic              wptrMoved,
  input  logic              preemptReq,
  input  logic              stackEmpty,
  input  logic              inHandler,
  output flowCtl_t          ctl,
  output logic              stalled
);

  logic regEq;
  logic bitSet;

  assign regEq  = (regVal == immVal);
  assign bitSet = regVal[bitSel];

  always_comb begin
    ctl = '0;
    ctl.nextSel = opValid ? NX_SEQ : NX_HOLD;
    stalled = 1'b0;
    if (opValid) begin
      case (flowOp_e'(opCode))
        OP_BREQI: if (regEq)   ctl.nextSel = NX_REL;
        OP_BRNEI: if (!regEq)  ctl.nextSel = NX_REL;
        OP_BREQB: if (bitSet)  ctl.nextSel = NX_REL;
        OP_BRNEB: if (!bitSet) ctl.nextSel = NX_REL;
        OP_CALL: begin
          ctl.push    = 1'b1;
          ctl.nextSel = NX_ABS;
        end
        OP_RET: begin
          ctl.pop     = 1'b1;
          ctl.nextSel = stackEmpty ? NX_SEQ : NX_STACK;
        end
        OP_BL: begin
          ctl.linkWr  = 1'b1;
          ctl.nextSel = NX_ABS;
        end
        OP_SRET:  ctl.nextSel = NX_LINK;
        OP_JUMPR: ctl.nextSel = NX_REGOFF;
        OP_JUMPA: ctl.nextSel = NX_ABS;
        OP_IRET: begin
          ctl.nextSel      = NX_SAVED;
          ctl.leaveHandler = 1'b1;
        end
        OP_WAITIN: if (!wptrMoved) begin
          ctl.nextSel = NX_HOLD;
          stalled     = 1'b1;
        end
        default: ctl.nextSel = NX_SEQ;
      endcase
    end
    ctl.takePreempt = preemptReq && !inHandler;
  end

endmodule

// File: rtl/flow_dpath.sv
module flow_dpath
  import flow_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int OFF_W   = 10,
  parameter int STACK_D = 8,
  localparam int PTR_W  = $clog2(STACK_D + 1),
  localparam int IDX_W  = (STACK_D > 1) ? $clog2(STACK_D) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  flowCtl_t          ctl,
  input  logic [OFF_W-1:0]  relOff,
  input  logic [ADDR_W-1:0] absAddr,
  input  logic [ADDR_W-1:0] regLow,
  input  logic [ADDR_W-1:0] preemptEntry,
  output logic [ADDR_W-1:0] pcQ,
  output logic [ADDR_W-1:0] linkQ,
  output logic              stackErr,
  output logic              stackEmpty,
  output logic              inHandler
);

  logic [ADDR_W-1:0] stackMem [STACK_D];
  logic [PTR_W-1:0]  depthQ;
  logic [ADDR_W-1:0] savedQ;
  logic [ADDR_W-1:0] seqPc, relPc, regOffPc, topAddr, nextPc;
  logic [IDX_W-1:0]  topIdx;
  logic              stackFull;

  assign stackEmpty = (depthQ == '0);
  assign stackFull  = (depthQ == PTR_W'(STACK_D));
  assign seqPc      = pcQ + ADDR_W'(1);
  assign relPc      = pcQ + ADDR_W'($signed(relOff));
  assign regOffPc   = absAddr + regLow;
  assign topIdx     = stackEmpty ? '0 : IDX_W'(depthQ - PTR_W'(1));
  assign topAddr    = stackMem[topIdx];

  always_comb begin
    case (ctl.nextSel)
      NX_SEQ:    nextPc = seqPc;
      NX_REL:    nextPc = relPc;
      NX_ABS:    nextPc = absAddr;
      NX_REGOFF: nextPc = regOffPc;
      NX_STACK:  nextPc = topAddr;
      NX_LINK:   nextPc = linkQ;
      NX_SAVED:  nextPc = savedQ;
      default:   nextPc = pcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcQ       <= '0;
      linkQ     <= '0;
      savedQ    <= '0;
      depthQ    <= '0;
      stackErr  <= 1'b0;
      inHandler <= 1'b0;
    end else begin
      pcQ <= ctl.takePreempt ? preemptEntry : nextPc;
      if (ctl.takePreempt) begin
        savedQ    <= nextPc;
        inHandler <= 1'b1;
      end else if (ctl.leaveHandler) begin
        inHandler <= 1'b0;
      end
      if (ctl.linkWr) linkQ <= seqPc;
      if (ctl.push) begin
        if (stackFull) stackErr <= 1'b1;
        else           depthQ   <= depthQ + PTR_W'(1);
      end else if (ctl.pop) begin
        if (stackEmpty) stackErr <= 1'b1;
        else            depthQ   <= depthQ - PTR_W'(1);
      end
    end
  end

  for (genvar gi = 0; gi < STACK_D; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ctl.push && !stackFull && depthQ == PTR_W'(gi))
        stackMem[gi] <= seqPc;
    end
  end

  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    depthQ <= PTR_W'(STACK_D));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.push && stackFull) |=> (depthQ == $past(depthQ)) && stackErr);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stackErr |=> stackErr);

  assert_link_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.linkWr |=> linkQ == $past(pcQ) + ADDR_W'(1));

  assert_preempt_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.takePreempt |=> (pcQ == $past(preemptEntry)) && inHandler);

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
  import flow_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 10,
  parameter int STACK_D = 8,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] immVal,
  input  logic [BIT_W-1:0]  bitSel,
  input  logic [OFF_W-1:0]  relOff,
  input  logic [ADDR_W-1:0] absAddr,
  input  logic              wptrMoved,
  input  logic              preemptReq,
  input  logic [ADDR_W-1:0] preemptEntry,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] linkReg,
  output logic              stalled,
  output logic              inHandler,
  output logic              stackErr
);

  flowCtl_t ctl;
  logic     stackEmpty;

  flow_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .opValid    (opValid),
    .opCode     (opCode),
    .regVal     (regVal),
    .immVal     (immVal),
    .bitSel     (bitSel),
    .wptrMoved  (wptrMoved),
    .preemptReq (preemptReq),
    .stackEmpty (stackEmpty),
    .inHandler  (inHandler),
    .ctl        (ctl),
    .stalled    (stalled)
  );

  flow_dpath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .STACK_D(STACK_D)) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .relOff       (relOff),
    .absAddr      (absAddr),
    .regLow       (regVal[ADDR_W-1:0]),
    .preemptEntry (preemptEntry),
    .pcQ          (fetchPc),
    .linkQ        (linkReg),
    .stackErr     (stackErr),
    .stackEmpty   (stackEmpty),
    .inHandler    (inHandler)
  );

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !(preemptReq && !inHandler)) |=> $stable(fetchPc));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!opValid && !(preemptReq && !inHandler)) |=> $stable(fetchPc));

endmodule

// File: tb/flow_sequencer_tb.sv
module flow_sequencer_tb;

  localparam int AW = 12;
  localparam int MASK = (1 << AW) - 1;

  typedef struct {
    int    pc;
    int    link;
    bit    err;
    bit    inH;
    string tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] regVal = '0, immVal = '0;
  logic [4:0]  bitSel = '0;
  logic [9:0]  relOff = '0;
  logic [11:0] absAddr = '0, preemptEntry = '0;
  logic        wptrMoved = 1'b0, preemptReq = 1'b0;
  logic [11:0] fetchPc, linkReg;
  logic        stalled, inHandler, stackErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t q[$];

  int mPc = 0, mLink = 0, mSaved = 0, mDepth = 0;
  int mStack[8];
  bit mErr = 0, mIn = 0;

  always #2.5 clk = ~clk;

  flow_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .regVal(regVal), .immVal(immVal), .bitSel(bitSel), .relOff(relOff),
    .absAddr(absAddr), .wptrMoved(wptrMoved), .preemptReq(preemptReq),
    .preemptEntry(preemptEntry), .fetchPc(fetchPc), .linkReg(linkReg),
    .stalled(stalled), .inHandler(inHandler), .stackErr(stackErr)
  );

  task automatic step(input int op = 0, input bit v = 1, input int rv = 0,
                      input int iv = 0, input int bs = 0, input int ro = 0,
                      input int aa = 0, input bit wm = 0, input bit pr = 0,
                      input int pe = 0, input string tag = "R2");
    int nxt;
    bit expStall, iret, take;
    expItem_t e;
    @(negedge clk);
    opValid = v; opCode = op[3:0]; regVal = rv; immVal = iv;
    bitSel = bs[4:0]; relOff = ro[9:0]; absAddr = aa[11:0];
    wptrMoved = wm; preemptReq = pr; preemptEntry = pe[11:0];
    nxt = v ? mPc + 1 : mPc;
    expStall = 0; iret = 0;
    if (v) begin
      case (op)
        1: if (rv == iv) nxt = mPc + ro;
        2: if (rv != iv) nxt = mPc + ro;
        3: if (rv[bs]) nxt = mPc + ro;
        4: if (!rv[bs]) nxt = mPc + ro;
        5: begin
          if (mDepth == 8) mErr = 1;
          else begin mStack[mDepth] = (mPc + 1) & MASK; mDepth++; end
          nxt = aa;
        end
        6: if (mDepth == 0) mErr = 1;
           else begin mDepth--; nxt = mStack[mDepth]; end
        7: begin mLink = (mPc + 1) & MASK; nxt = aa; end
        8: nxt = mLink;
        9: nxt = aa + rv;
        10: nxt = aa;
        11: begin nxt = mSaved; iret = 1; end
        12: if (!wm) begin nxt = mPc; expStall = 1; end
        default: ;
      endcase
    end
    nxt = nxt & MASK;
    take = pr && !mIn;
    if (take) begin mSaved = nxt; nxt = pe & MASK; mIn = 1; end
    else if (iret) mIn = 0;
    mPc = nxt;
    #1;
    checks++;
    if (stalled !== expStall) begin
      errors++;
      $display("FAIL %s stalled: actual %0b expected %0b", (op == 12) ? "R9" : tag, stalled, expStall);
    end
    e.pc = mPc; e.link = mLink; e.err = mErr; e.inH = mIn; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      checks++;
      if (int'(fetchPc) != e.pc || int'(linkReg) != e.link ||
          stackErr !== e.err || inHandler !== e.inH) begin
        errors++;
        $display("FAIL %s: actual pc=%0d link=%0d err=%0b inH=%0b expected pc=%0d link=%0d err=%0b inH=%0b",
                 e.tag, fetchPc, linkReg, stackErr, inHandler, e.pc, e.link, e.err, e.inH);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    checks++;
    if (fetchPc !== 0 || linkReg !== 0 || stackErr !== 0 || inHandler !== 0) begin
      errors++;
      $display("FAIL R1: actual pc=%0d link=%0d err=%0b inH=%0b expected all zero",
               fetchPc, linkReg, stackErr, inHandler);
    end
    // R2: sequential flow, unused codes, idle hold
    step(.op(0), .tag("R2"));
    step(.op(0), .tag("R2"));
    step(.op(14), .tag("R2"));
    step(.op(5), .v(0), .aa(99), .tag("R2"));
    // R3: equality branches, backwards and forwards
    step(.op(1), .rv(7), .iv(7), .ro(-2), .tag("R3"));
    step(.op(1), .rv(7), .iv(8), .ro(-2), .tag("R3"));
    step(.op(2), .rv(7), .iv(8), .ro(20), .tag("R3"));
    step(.op(2), .rv(9), .iv(9), .ro(20), .tag("R3"));
    // R4: bit branches at both ends
    step(.op(3), .rv(32'h8000_0000), .bs(31), .ro(5), .tag("R4"));
    step(.op(3), .rv(32'h7fff_ffff), .bs(31), .ro(5), .tag("R4"));
    step(.op(4), .rv(32'hffff_fffe), .bs(0), .ro(-3), .tag("R4"));
    step(.op(4), .rv(1), .bs(0), .ro(-3), .tag("R4"));
    // R5: nested call and return
    step(.op(5), .aa(100), .tag("R5"));
    step(.op(5), .aa(300), .tag("R5"));
    step(.op(6), .tag("R5"));
    step(.op(6), .tag("R5"));
    // R7: link-style call leaves stack alone
    step(.op(7), .aa(200), .tag("R7"));
    step(.op(0), .tag("R7"));
    step(.op(8), .tag("R7"));
    // R8: register-indexed with wrap, absolute
    step(.op(9), .aa(4000), .rv(200), .tag("R8"));
    step(.op(10), .aa(1234), .tag("R8"));
    // R9: wait for input
    step(.op(12), .tag("R9"));
    step(.op(12), .tag("R9"));
    step(.op(12), .wm(1), .tag("R9"));
    // R10/R11: preempt during a stalled wait, nested request masked
    step(.op(12), .pr(1), .pe(3000), .tag("R10"));
    step(.op(0), .pr(1), .pe(50), .tag("R10"));
    step(.op(11), .tag("R11"));
    step(.op(12), .wm(1), .tag("R11"));
    step(.op(0), .pr(1), .pe(2500), .tag("R10"));
    step(.op(11), .tag("R11"));
    // R6: overflow on ninth call, then drain and underflow
    for (int i = 0; i < 9; i++) step(.op(5), .aa(16 * (i + 1)), .tag("R6"));
    for (int i = 0; i < 9; i++) step(.op(6), .tag("R6"));
    step(.op(0), .tag("R6"));
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule